// File: doc/BRIEF.md
# Wiper Register Controller with Deferred Nonvolatile Commit

This block keeps the setting of a 128-step digital potentiometer. It sits behind a serial-bus slave, which delivers decoded events: a data byte acknowledged for a given register address, the end of a transaction by STOP, and the end of a transaction by a repeated START. A written code reaches the wiper output at once. Whether the same code is also kept in the emulated nonvolatile store depends on a mode bit and on how the transaction ends.

In the persistent mode a wiper write is staged. A STOP then opens a commit window that keeps the busy flag high for a programmable number of clock cycles, and at the end of that window the staged code is stored. A repeated START discards the staged code. In the volatile-only mode a wiper write only moves the wiper. At reset the store holds its factory code. During a programmable recall window busy stays high, and when the window ends the stored code is copied into the wiper. A saturating counter of started commits is brought out so that a test environment can see which writes actually wore the store.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: From reset, busy stays high for exactly RECALL_CYCLES cycles. The wiper reads 0 during that window. In the cycle busy falls, the wiper takes the stored code, which is DEFAULT_CODE (40h) after reset, and the mode bit is 0.
- R2: A write event to address 00h while busy is low sets the wiper to the low 7 bits of the data in the next cycle. Bit 7 of the data is dropped.
- R3: The read port is combinational on rd_addr. Address 00h returns {0, wiper}, address 02h returns {mode, 7'b0}, and any other address returns 00h.
- R4: A write event to address 02h while idle sets the mode from data bit 7 and ignores data bits 6:0. Changing the mode leaves the wiper and the stored code unchanged.
- R5: In mode 0, a wiper write followed by a STOP event raises busy in the next cycle for exactly COMMIT_CYCLES cycles. The stored code takes the last staged code in the cycle busy falls, and nv_writes rises by one.
- R6: In mode 1, a wiper write followed by a STOP event starts no busy window, leaves the stored code unchanged and does not increment nv_writes.
- R7: A repeated-START event discards a staged code, so a STOP that follows it starts no commit.
- R8: While busy is high, write events are ignored: the wiper, the mode and the staged code are unchanged, and a later STOP starts no commit.
- R9: nv_writes saturates at 2^CNT_W-1 and holds there on further commits.
- R10: Write events to any address other than 00h and 02h change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| wr_en | input | 1 | One-cycle pulse: data byte acknowledged |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Written data byte |
| stop_evt | input | 1 | One-cycle pulse: transaction ended by STOP |
| rstart_evt | input | 1 | One-cycle pulse: transaction ended by repeated START |
| rd_addr | input | 8 | Register address for the read port |
| wiper | output | 7 | Current wiper code |
| busy | output | 1 | High during recall and during a commit |
| stored_code | output | 7 | Code held in the emulated nonvolatile store |
| rd_data | output | 8 | Read data for rd_addr |
| nv_writes | output | CNT_W | Saturating count of started commits |

## Verification
The wiper and the mode change in the first cycle after the write event. Busy rises in the first cycle after a STOP and stays high for COMMIT_CYCLES cycles, and the stored code changes in the same cycle busy falls. rd_data follows rd_addr within the same cycle. The bench drives every input 1 ns after a rising edge. It compares a behavioural model against all outputs at each falling edge, so each result is sampled after the edge that produces it and before the next one. Directed checks also count the busy cycles one falling edge at a time, so that the window lengths are checked exactly.

// File: rtl/wnv_pkg.sv
package wnv_pkg;

    localparam int unsigned AW = 8;
    localparam logic [AW-1:0] ADDR_WIPER = 8'h00;
    localparam logic [AW-1:0] ADDR_CTRL  = 8'h02;

    typedef enum logic [1:0] {
        SEL_WIPER,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        if (a == ADDR_WIPER)     return SEL_WIPER;
        else if (a == ADDR_CTRL) return SEL_CTRL;
        else                     return SEL_NONE;
    endfunction

endpackage

// File: rtl/wnv_timer.sv
module wnv_timer #(
    parameter int unsigned LEN           = 4,
    parameter bit          LOAD_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);

    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LEN_V = CW'(LEN);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] rst_val;

    generate
        if (LOAD_AT_RESET) begin : g_load
            assign rst_val = LEN_V;
        end else begin : g_idle
            assign rst_val = '0;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LEN_V;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= rst_val;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == ONE_V);

    AST_TIMER_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !start); // R5

endmodule

// File: rtl/wnv_satcnt.sv
module wnv_satcnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAX_V = '1;
    localparam logic [W-1:0] ONE_V = W'(1);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc && (count_q != MAX_V)) begin
            count_d = count_q + ONE_V;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;

    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == MAX_V) |=> (count_q == MAX_V)); // R9

endmodule

// File: rtl/wnv_regs.sv
module wnv_regs
    import wnv_pkg::*;
#(
    parameter int unsigned W            = 7,
    parameter int unsigned DEFAULT_CODE = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          recall_last,
    input  logic          commit_last,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W:0]    wr_data,
    input  logic          stop_evt,
    input  logic          rstart_evt,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  wiper,
    output logic [W-1:0]  stored_code,
    output logic [W:0]    rd_data,
    output logic          commit_start
);

    localparam logic [W-1:0] DEFAULT_V = W'(DEFAULT_CODE);

    typedef struct packed {
        logic [W-1:0] wiper;
        logic         mode;
        logic         pending;
        logic [W-1:0] staged;
        logic [W-1:0] stored;
    } regs_t;

    regs_t st_d, st_q;
    reg_sel_e wr_sel, rd_sel;

    assign wr_sel = decode_addr(wr_addr);
    assign rd_sel = decode_addr(rd_addr);

    always_comb begin
        st_d         = st_q;
        commit_start = 1'b0;

        if (recall_last) st_d.wiper  = st_q.stored;
        if (commit_last) st_d.stored = st_q.staged;

        if (wr_en && !busy) begin
            case (wr_sel)
                SEL_WIPER: begin
                    st_d.wiper = wr_data[W-1:0];
                    if (!st_q.mode) begin
                        st_d.pending = 1'b1;
                        st_d.staged  = wr_data[W-1:0];
                    end
                end
                SEL_CTRL: st_d.mode = wr_data[W];
                default: ;
            endcase
        end

        if (rstart_evt) begin
            st_d.pending = 1'b0;
        end else if (stop_evt && st_q.pending && !busy) begin
            commit_start = 1'b1;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wiper   <= '0;
            st_q.mode    <= 1'b0;
            st_q.pending <= 1'b0;
            st_q.staged  <= DEFAULT_V;
            st_q.stored  <= DEFAULT_V;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_WIPER: rd_data = {1'b0, st_q.wiper};
            SEL_CTRL:  rd_data = {st_q.mode, {W{1'b0}}};
            default:   rd_data = '0;
        endcase
    end

    assign wiper       = st_q.wiper;
    assign stored_code = st_q.stored;

    AST_WIPER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr == ADDR_WIPER) |=> (wiper == $past(wr_data[W-1:0]))); // R2

    AST_MODE_KEEPS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_addr == ADDR_CTRL) |=> $stable(wiper)); // R4

    AST_STORE_ONLY_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(stored_code)); // R6

    AST_RSTART_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_evt |=> !commit_start); // R7

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !recall_last) |=> $stable(wiper)); // R8

endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl
    import wnv_pkg::*;
#(
    parameter int unsigned W             = 7,
    parameter int unsigned DEFAULT_CODE  = 64,
    parameter int unsigned RECALL_CYCLES = 600000,
    parameter int unsigned COMMIT_CYCLES = 4000000,
    parameter int unsigned CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [W:0]       wr_data,
    input  logic             stop_evt,
    input  logic             rstart_evt,
    input  logic [7:0]       rd_addr,
    output logic [W-1:0]     wiper,
    output logic             busy,
    output logic [W-1:0]     stored_code,
    output logic [W:0]       rd_data,
    output logic [CNT_W-1:0] nv_writes
);

    logic recall_active, recall_last;
    logic commit_active, commit_last;
    logic commit_start;

    wnv_timer #(.LEN(RECALL_CYCLES), .LOAD_AT_RESET(1'b1)) recall_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (1'b0),
        .active (recall_active),
        .last   (recall_last)
    );

    wnv_timer #(.LEN(COMMIT_CYCLES), .LOAD_AT_RESET(1'b0)) commit_tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (commit_start),
        .active (commit_active),
        .last   (commit_last)
    );

    assign busy = recall_active | commit_active;

    wnv_regs #(.W(W), .DEFAULT_CODE(DEFAULT_CODE)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .recall_last  (recall_last),
        .commit_last  (commit_last),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .stop_evt     (stop_evt),
        .rstart_evt   (rstart_evt),
        .rd_addr      (rd_addr),
        .wiper        (wiper),
        .stored_code  (stored_code),
        .rd_data      (rd_data),
        .commit_start (commit_start)
    );

    wnv_satcnt #(.W(CNT_W)) wear_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (commit_start),
        .count (nv_writes)
    );

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt)); // R5

endmodule

// File: tb/wiper_nv_ctrl_tb_top.sv
`timescale 1ns/100ps
module wiper_nv_ctrl_tb_top;

    localparam int RC   = 6;
    localparam int NC   = 10;
    localparam int CW   = 3;
    localparam int CMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          stop_evt = 1'b0;
    logic          rstart_evt = 1'b0;
    logic [7:0]    rd_addr = '0;
    logic [6:0]    wiper;
    logic          busy;
    logic [6:0]    stored_code;
    logic [7:0]    rd_data;
    logic [CW-1:0] nv_writes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    wiper_nv_ctrl #(
        .W(7), .DEFAULT_CODE(64), .RECALL_CYCLES(RC),
        .COMMIT_CYCLES(NC), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stop_evt(stop_evt), .rstart_evt(rstart_evt),
        .rd_addr(rd_addr), .wiper(wiper), .busy(busy),
        .stored_code(stored_code), .rd_data(rd_data), .nv_writes(nv_writes)
    );

    // behavioural reference model
    int m_wiper = 0, m_mode = 0, m_pend = 0, m_staged = 64, m_stored = 64;
    int m_recall = RC, m_commit = 0, m_count = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wiper = 0; m_mode = 0; m_pend = 0; m_staged = 64; m_stored = 64;
            m_recall = RC; m_commit = 0; m_count = 0;
        end else begin
            int bsy, old_pend, old_mode;
            bsy = (m_recall > 0 || m_commit > 0) ? 1 : 0;
            old_pend = m_pend;
            old_mode = m_mode;
            if (m_recall > 0) begin
                if (m_recall == 1) m_wiper = m_stored;
                m_recall = m_recall - 1;
            end else if (m_commit > 0) begin
                if (m_commit == 1) m_stored = m_staged;
                m_commit = m_commit - 1;
            end
            if (wr_en && bsy == 0) begin
                if (wr_addr == 8'h00) begin
                    m_wiper = int'(wr_data) % 128;
                    if (old_mode == 0) begin
                        m_pend = 1;
                        m_staged = int'(wr_data) % 128;
                    end
                end else if (wr_addr == 8'h02) begin
                    m_mode = int'(wr_data[7]);
                end
            end
            if (rstart_evt) m_pend = 0;
            else if (stop_evt && old_pend == 1 && bsy == 0) begin
                m_commit = NC;
                if (m_count < CMAX) m_count = m_count + 1;
                m_pend = 0;
            end
        end
    end

    function automatic int exp_rd(input int a);
        if (a == 0) return m_wiper;
        if (a == 2) return m_mode * 128;
        return 0;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 wiper", int'(wiper), m_wiper);
            chk("R5 busy", int'(busy), (m_recall > 0 || m_commit > 0) ? 1 : 0);
            chk("R5 stored", int'(stored_code), m_stored);
            chk("R9 count", int'(nv_writes), m_count);
            chk("R3 rd_data", int'(rd_data), exp_rd(int'(rd_addr)));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic stop_e();
        @(posedge clk); #1; stop_evt = 1'b1;
        @(posedge clk); #1; stop_evt = 1'b0;
    endtask

    task automatic rstart_e();
        @(posedge clk); #1; rstart_evt = 1'b1;
        @(posedge clk); #1; rstart_evt = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        @(negedge clk);
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            finish_run();
        end
    end

    initial begin
        int n;
        #1 rst_n = 1'b0;
        started = 1'b1;
        @(negedge clk);
        chk("R1 busy in reset", int'(busy), 1);
        chk("R1 wiper in reset", int'(wiper), 0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        busy_len(n);
        chk("R1 recall length", n, RC);
        chk("R1 recalled wiper", int'(wiper), 8'h40);
        rd_addr = 8'h02; #0.5;
        chk("R1 mode after reset", int'(rd_data), 0);

        // R2 / R3: wiper write, bit 7 dropped
        rd_addr = 8'h00;
        wr(8'h00, 8'hA5);
        @(negedge clk);
        chk("R2 wiper written", int'(wiper), 8'h25);
        chk("R3 read wiper", int'(rd_data), 8'h25);
        chk("R5 store before stop", int'(stored_code), 8'h40);

        // R5: commit on stop in mode 0
        stop_e();
        busy_len(n);
        chk("R5 commit length", n, NC);
        chk("R5 stored after commit", int'(stored_code), 8'h25);
        chk("R5 count", int'(nv_writes), 1);

        // R8: writes during busy ignored
        wr(8'h00, 8'h10);
        stop_e();
        wr(8'h00, 8'h11);
        @(negedge clk);
        chk("R8 wiper frozen while busy", int'(wiper), 8'h10);
        busy_len(n);
        stop_e();
        @(negedge clk);
        chk("R8 no commit after ignored write", int'(busy), 0);
        chk("R8 count", int'(nv_writes), 2);

        // R4: mode bit, other bits ignored
        wr(8'h02, 8'hFF);
        rd_addr = 8'h02;
        @(negedge clk);
        chk("R4 ctrl readback", int'(rd_data), 8'h80);
        chk("R4 wiper kept", int'(wiper), 8'h10);
        chk("R4 store kept", int'(stored_code), 8'h10);

        // R6: mode 1 write does not commit
        wr(8'h00, 8'h33);
        stop_e();
        @(negedge clk);
        chk("R6 no busy", int'(busy), 0);
        chk("R6 wiper", int'(wiper), 8'h33);
        chk("R6 store", int'(stored_code), 8'h10);
        chk("R6 count", int'(nv_writes), 2);

        // R7: repeated START cancels
        wr(8'h02, 8'h7F);
        rd_addr = 8'h02; #0.5;
        chk("R4 mode cleared", int'(rd_data), 0);
        wr(8'h00, 8'h12);
        rstart_e();
        stop_e();
        @(negedge clk);
        chk("R7 no busy", int'(busy), 0);
        chk("R7 store", int'(stored_code), 8'h10);
        chk("R7 wiper", int'(wiper), 8'h12);

        // R10: other addresses ignored
        wr(8'h05, 8'h7F);
        wr(8'h01, 8'hFF);
        rd_addr = 8'h05;
        @(negedge clk);
        chk("R10 read other", int'(rd_data), 0);
        chk("R10 wiper", int'(wiper), 8'h12);
        rd_addr = 8'h02; #0.5;
        chk("R10 mode", int'(rd_data), 0);

        // R9: saturation
        for (int i = 0; i < 7; i++) begin
            wr(8'h00, 8'(i + 1));
            stop_e();
            busy_len(n);
        end
        chk("R9 saturated", int'(nv_writes), CMAX);
        chk("R9 last stored", int'(stored_code), 7);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule